// File: doc/BRIEF.md
# Incremental ADC Conversion Sequencer

This block holds the digital control and decimation for a first-order incremental delta-sigma converter. An external integrator and comparator produce a pulse stream. A free-running timer supplies a tick every timer period. The sequencer alternates an integrate window of 2^(NUMBITS-6) timer periods with a single reset period. During the reset period it holds the integrator in reset and ignores the comparator. It counts comparator pulses during each integrate window in a counter split into a low byte and a high byte. At the close of the window it turns the count into a signed sample, saturating at the top code, and raises a data-valid flag.

A host pulses `start_i` together with a conversion count. A count of zero makes the converter run until the next start. A nonzero count makes it produce exactly that many samples and then park with the integrator held in reset. The FSM has three states. `ST_IDLE` means parked. `ST_RESET_WIN` is the one-period integrator reset. `ST_INTEGRATE` is the counting window. The transitions are as follows:
- start: any state to `ST_RESET_WIN`.
- open: `ST_RESET_WIN` to `ST_INTEGRATE` on a tick.
- close-continue: `ST_INTEGRATE` to `ST_RESET_WIN` on the final tick.
- close-stop: `ST_INTEGRATE` to `ST_IDLE` on the final tick of the last counted conversion.

Top module: `incr_adc_seq`

## Requirements
- R1: After reset the block is parked: `integ_rst_o`=1, `active_o`=0, `valid_o`=0 and `sample_o`=0.
- R2: A `start_i` pulse takes priority over every other event. It loads `conv_count_i`, clears `valid_o`, and in the next cycle `integ_rst_o`=1 and `active_o`=1 (the reset period).
- R3: The reset period ends on the first tick after it begins, and `integ_rst_o` falls in the following cycle. The integrate window then closes on its 2^(NUMBITS-6)-th tick (64 by default), and the next reset period begins in the following cycle.
- R4: `comp_i` passes through two synchronizer flops and a rising-edge detector. Each rising edge adds one to the window count exactly once. It counts only while integrating, and not in the cycle of the closing tick.
- R5: The high byte is preset to -(2^(NUMBITS-7)) and the low byte to FFh. The low byte counts down, and the high byte increments on each low-byte underflow. At close, raw = {high, ~low}, which equals k - 2^(NUMBITS+1) modulo 2^16 for k pulses. `sample_o` is raw arithmetically shifted right by 2, so zero pulses give F800h.
- R6: If the high byte equals +2^(NUMBITS-7) at close, raw becomes {high-1, FFh} instead. With the defaults, 16384 pulses give `sample_o`=07FFh.
- R7: `valid_o` rises in the cycle after the closing tick and stays set until a `clr_valid_i` pulse. A close and a clear in the same cycle leave it set.
- R8: With a conversion count of zero, the converter keeps alternating windows without stopping.
- R9: With a count N>0, exactly N samples are produced. The block then parks with `active_o`=0 and `integ_rst_o`=1, and later ticks and pulses have no effect.
- R10: `sample_o` changes only in the cycle a new sample is written, and holds its value otherwise.
- R11: A start during a conversion abandons it with no sample and restarts from a reset period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; loads the conversion count |
| conv_count_i | input | CNT_W | Number of conversions, 0 = free-running |
| tick_i | input | 1 | One-cycle timer period tick |
| comp_i | input | 1 | Asynchronous comparator pulse stream |
| clr_valid_i | input | 1 | One-cycle clear of the data-valid flag |
| integ_rst_o | output | 1 | Holds the external integrator in reset |
| active_o | output | 1 | Converter running |
| valid_o | output | 1 | New sample available |
| sample_o | output | 16 | Signed sample, sign-extended |

## Verification
`integ_rst_o` and `active_o` react one cycle after the tick or start that changes state. `sample_o` and `valid_o` update one cycle after the closing tick. A comparator rising edge that is present at one rising clock edge is added to the count two edges later. The bench keeps a behavioural model that applies these latencies at each rising edge. It compares all four outputs against that model at the following falling edge, so every sample is taken half a cycle after the outputs have settled. The model also marks the cycle in which the window closes, so the bench can place a clear in exactly that cycle to check R7.

// File: rtl/incr_adc_pkg.sv
package incr_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESET_WIN,
        ST_INTEGRATE
    } adc_state_e;

    // Join the two counter halves, saturate on the top code, divide by four.
    function automatic logic [15:0] form_sample(input logic [7:0] hi,
                                                input logic [7:0] lo,
                                                input logic [7:0] sat_hi);
        logic signed [15:0] raw;
        raw = {hi, ~lo};
        if (hi == sat_hi) begin
            raw = {hi - 8'd1, 8'hFF};
        end
        return 16'(raw >>> 2);
    endfunction

endpackage

// File: rtl/comp_edge_sync.sv
module comp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], async_i};
        end
    end

    assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/split_pulse_counter.sv
module split_pulse_counter #(
    parameter int         LO_W      = 8,
    parameter int         HI_W      = 8,
    parameter logic [7:0] HI_PRESET = 8'hE0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            preset_i,
    input  logic            dec_i,
    output logic [HI_W-1:0] hi_o,
    output logic [LO_W-1:0] lo_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_o <= '1;
            hi_o <= HI_W'(HI_PRESET);
        end else if (preset_i) begin
            lo_o <= '1;
            hi_o <= HI_W'(HI_PRESET);
        end else if (dec_i) begin
            lo_o <= lo_o - 1'b1;
            if (lo_o == '0) begin
                hi_o <= hi_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/incr_adc_seq.sv
module incr_adc_seq #(
    parameter int NUMBITS = 12,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] conv_count_i,
    input  logic             tick_i,
    input  logic             comp_i,
    input  logic             clr_valid_i,
    output logic             integ_rst_o,
    output logic             active_o,
    output logic             valid_o,
    output logic [15:0]      sample_o
);
    import incr_adc_pkg::*;

    localparam int         WIN_TICKS = 1 << (NUMBITS - 6);
    localparam int         TMR_W     = NUMBITS - 5;
    localparam logic [7:0] HI_PRESET = 8'(-(1 << (NUMBITS - 7)));
    localparam logic [7:0] SAT_HI    = 8'(1 << (NUMBITS - 7));

    adc_state_e       state, state_nxt;
    logic [TMR_W-1:0] win_left;
    logic [CNT_W-1:0] conv_left;
    logic             comp_rise;
    logic [7:0]       cnt_hi, cnt_lo;
    logic             win_open, win_close, cnt_dec;

    comp_edge_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (comp_i),
        .rise_o  (comp_rise)
    );

    assign win_open  = !start_i && state == ST_RESET_WIN && tick_i;
    assign win_close = !start_i && state == ST_INTEGRATE && tick_i
                       && win_left == TMR_W'(1);
    assign cnt_dec   = !start_i && state == ST_INTEGRATE && comp_rise && !win_close;

    split_pulse_counter #(.LO_W(8), .HI_W(8), .HI_PRESET(HI_PRESET)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_i (win_open),
        .dec_i    (cnt_dec),
        .hi_o     (cnt_hi),
        .lo_o     (cnt_lo)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (start_i) begin
            state_nxt = ST_RESET_WIN;
        end else begin
            unique case (state)
                ST_IDLE:      state_nxt = ST_IDLE;
                ST_RESET_WIN: if (tick_i) state_nxt = ST_INTEGRATE;
                ST_INTEGRATE: if (win_close)
                                  state_nxt = (conv_left == CNT_W'(1)) ? ST_IDLE
                                                                      : ST_RESET_WIN;
                default:      state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // window timer, conversion countdown, sample and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_left  <= '0;
            conv_left <= '0;
            valid_o   <= 1'b0;
            sample_o  <= '0;
        end else if (start_i) begin
            conv_left <= conv_count_i;
            valid_o   <= 1'b0;
        end else begin
            if (win_open) begin
                win_left <= TMR_W'(WIN_TICKS);
            end else if (state == ST_INTEGRATE && tick_i) begin
                win_left <= win_left - 1'b1;
            end
            if (win_close) begin
                sample_o <= form_sample(cnt_hi, cnt_lo, SAT_HI);
                valid_o  <= 1'b1;
                if (conv_left != '0) conv_left <= conv_left - 1'b1;
            end else if (clr_valid_i) begin
                valid_o <= 1'b0;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        integ_rst_o = (state != ST_INTEGRATE);
        active_o    = (state != ST_IDLE);
    end
endmodule

// File: rtl/incr_adc_seq_chk.sv
module incr_adc_seq_chk #(
    parameter int NUMBITS = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        tick_i,
    input logic        clr_valid_i,
    input logic        integ_rst_o,
    input logic        active_o,
    input logic        valid_o,
    input logic [15:0] sample_o
);
    localparam int EXT_W = 17 - NUMBITS;

    // R2
    start_enters_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> integ_rst_o && active_o && !valid_o);

    // R3
    integ_opens_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(integ_rst_o) |-> $past(tick_i));

    // R7
    valid_rises_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(tick_i));

    // R7
    clear_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid_i && !tick_i && !start_i) |=> !valid_o);

    // R9
    parked_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> integ_rst_o);

    // R10
    sample_only_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_o) |-> valid_o && $past(tick_i));

    // R5
    sample_sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sample_o[15:NUMBITS-1]) == 0 ||
        $countones(sample_o[15:NUMBITS-1]) == EXT_W);
endmodule

bind incr_adc_seq incr_adc_seq_chk #(.NUMBITS(NUMBITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .tick_i      (tick_i),
    .clr_valid_i (clr_valid_i),
    .integ_rst_o (integ_rst_o),
    .active_o    (active_o),
    .valid_o     (valid_o),
    .sample_o    (sample_o)
);

// File: tb/tb_incr_adc_seq.sv
module tb_incr_adc_seq;
    localparam int NUMBITS = 12;
    localparam int CNT_W   = 8;
    localparam int WIN     = 1 << (NUMBITS - 6);
    localparam int OFFS    = 1 << (NUMBITS + 1);
    localparam logic [7:0] SAT = 8'(1 << (NUMBITS - 7));

    logic clk = 0, rst_n = 0, start_i = 0, tick_i = 0, comp_i = 0, clr_valid_i = 0;
    logic [CNT_W-1:0] conv_count_i = '0;
    logic integ_rst_o, active_o, valid_o;
    logic [15:0] sample_o;

    always #2 clk = ~clk;

    incr_adc_seq #(.NUMBITS(NUMBITS), .CNT_W(CNT_W)) dut (.*);

    int total = 0, bad = 0, cycles = 0;
    int tick_period = 20, pulse_div = 0, tcnt = 0, pcnt = 0;
    bit tick_en = 0, clr_req = 0, clr_at_close = 0, cmp_on = 0;
    int close_clears = 0;

    // behavioural model
    int mst = 0, mtimer = 0, mcnt = 0, mk = 0, nread = 0;
    bit mvalid = 0, s1 = 0, s2 = 0, s3 = 0;
    logic [15:0] msample = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst = 0; mtimer = 0; mcnt = 0; mk = 0; mvalid = 0; msample = '0;
            s1 = 0; s2 = 0; s3 = 0;
        end else begin
            bit edge_seen, setv;
            logic [15:0] raw;
            edge_seen = s2 && !s3;
            setv = 0;
            if (start_i) begin
                mst = 1; mcnt = conv_count_i; mvalid = 0;
            end else begin
                if (mst == 1) begin
                    if (tick_i) begin mst = 2; mtimer = WIN; mk = 0; end
                end else if (mst == 2) begin
                    if (tick_i && mtimer == 1) begin
                        raw = 16'(mk - OFFS);
                        if (raw[15:8] == SAT) raw = {raw[15:8] - 8'd1, 8'hFF};
                        msample = {{2{raw[15]}}, raw[15:2]};
                        setv = 1; mvalid = 1; nread++;
                        if (mcnt == 0) mst = 1;
                        else if (mcnt == 1) begin mcnt = 0; mst = 0; end
                        else begin mcnt--; mst = 1; end
                    end else begin
                        if (tick_i) mtimer--;
                        if (edge_seen) mk++;
                    end
                end
                if (clr_valid_i && !setv) mvalid = 0;
            end
            s3 = s2; s2 = s1; s1 = comp_i;
        end
    end

    // stimulus generators and per-cycle comparison
    always @(negedge clk) begin
        cycles++;
        if (cmp_on) begin
            chk(integ_rst_o == (mst != 2), "R3 integ_rst_o", integ_rst_o, mst != 2);
            chk(active_o == (mst != 0), "R9 active_o", active_o, mst != 0);
            chk(valid_o == mvalid, "R7 valid_o", valid_o, mvalid);
            chk(sample_o == msample, "R5 sample_o (R4 count)", sample_o, msample);
        end
        if (tick_en && tcnt >= tick_period - 1) begin tick_i = 1; tcnt = 0; end
        else begin tick_i = 0; tcnt++; end
        if (pulse_div > 0) begin comp_i = (pcnt == 0); pcnt = (pcnt + 1) % pulse_div; end
        else comp_i = 0;
        if (clr_at_close && tick_i && mst == 2 && mtimer == 1) begin
            clr_valid_i = 1; close_clears++;
        end else clr_valid_i = clr_req;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input int cnt);
        @(negedge clk);
        #1 start_i = 1; conv_count_i = CNT_W'(cnt);
        @(negedge clk);
        #1 start_i = 0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (active_o && guard < 60000) begin @(negedge clk); guard++; end
        #1;
    endtask

    initial begin
        #100000000;
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=finish", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r0;
        logic [15:0] held;
        cyc(3);
        #1;
        // R1: parked after reset
        chk(integ_rst_o && !active_o && !valid_o && sample_o == 0, "R1 reset state",
            {integ_rst_o, active_o, valid_o}, 3'b100);
        rst_n = 1;
        cmp_on = 1;
        tick_en = 1;
        cyc(30);

        // counted run of three with no pulses
        r0 = nread;
        do_start(3);
        #1 chk(integ_rst_o && active_o && !valid_o, "R2 start enters reset period",
               {integ_rst_o, active_o, valid_o}, 3'b110);
        wait_idle();
        chk(nread - r0 == 3, "R9 exactly N samples", nread - r0, 3);
        chk(sample_o == 16'hF800, "R5 zero pulses", sample_o, 16'hF800);
        held = sample_o;
        pulse_div = 3;
        cyc(400);
        #1 chk(!active_o && integ_rst_o && sample_o == held, "R9 parked ignores ticks",
               sample_o, held);
        chk(sample_o == held, "R10 sample holds", sample_o, held);
        clr_req = 1; cyc(1); #1 clr_req = 0; cyc(1); #1;
        chk(!valid_o, "R7 clear drops valid", valid_o, 0);

        // free-running with pulses and a clear on the closing cycle
        pulse_div = 5;
        clr_at_close = 1;
        r0 = nread;
        do_start(0);
        while (nread - r0 < 4) cyc(1);
        clr_at_close = 0;
        cyc(2); #1;
        chk(close_clears > 0 && valid_o, "R7 close beats clear", valid_o, 1);
        chk(active_o, "R8 free-running continues", active_o, 1);
        chk(sample_o != 16'hF800, "R4 pulses counted", sample_o, 16'hF800);

        // restart in the middle of a window
        cyc(300);
        r0 = nread;
        do_start(1);
        wait_idle();
        chk(nread - r0 == 1, "R11 restart yields one sample", nread - r0, 1);

        // saturation: about 2^(NUMBITS+2) pulses in one window
        tick_period = 512;
        pulse_div = 2;
        do_start(1);
        wait_idle();
        chk(sample_o == 16'h07FF, "R6 saturation", sample_o, 16'h07FF);

        cyc(5);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule